// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is a serial-peripheral slave that lets an external master read and write an on-chip byte register file. The three serial inputs (select, clock, data in) are resynchronised into the system clock domain and their edges are found by oversampling. Nothing is clocked by the serial clock itself. The slave data output comes with a separate drive-enable, so the pad can be tri-stated.

A transaction begins when select falls. The first byte is a command. Its top bit chooses the direction and its lower seven bits give a starting register address. In a write, every complete byte that follows is stored at the current address, and the address then moves on. In a read, the slave returns the contents of the addressed register and then the registers after it. Both directions continue for as long as select stays low, and the address wraps at the end of the register file. Raising select ends the transaction at once and drops any incomplete byte.

Top module: `spi_reg_slave`

## Requirements
- R1: Clock-idle-low (mode 0) and clock-idle-high (mode 3) transactions both work. Input data is taken at rising serial-clock edges.
- R2: Bytes travel most significant bit first. The slave data output changes only after a falling serial-clock edge.
- R3: In the command byte, bit 7 set to 0 selects write and set to 1 selects read, and bits 6..0 hold the start address. A read transaction never asserts the write strobe.
- R4: In a write, each complete byte after the command causes exactly one single-cycle write strobe. The strobe carries that byte and the current address, and the address then advances by one.
- R5: In a read, the bytes after the command return the register at the start address, then the following registers in turn. Each value is fetched after the final rising edge of the previous byte and presented MSB first from the next falling edge.
- R6: The address that follows NUM_REGS-1 is 0, for both reads and writes.
- R7: The output enable is low out of reset and whenever select is high. It is high while select is low.
- R8: If select rises in the middle of a byte, that partial byte produces no write, and the bit count restarts so that the next transaction is byte-aligned.
- R9: While the command byte is being received, the slave drives 0 on its data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_sck | input | 1 | Serial clock from the master |
| spi_sdi | input | 1 | Serial data from master to slave |
| spi_sdo | output | 1 | Serial data from slave to master |
| spi_sdo_oe | output | 1 | Drive enable for spi_sdo (1 = drive) |
| reg_addr_o | output | 7 | Register file address |
| reg_wdata_o | output | 8 | Register file write data |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_rdata_i | input | 8 | Register file read data for reg_addr_o |

## Verification
The bench sweeps every start address of a 16-register file. At each one it writes three distinct bytes and reads them back, first in clock-idle-low mode and then in clock-idle-high mode. This separates address decode, increment and wrap errors from bit-order and edge-choice errors, because each byte value depends on its address, its position and the mode. Transactions cut off mid-byte in both modes, each followed by a full read, show whether partial bytes leak into the file and whether bit alignment recovers. The command byte's echo and the write-strobe count during reads tell a mis-decoded direction bit apart from a fault in the data path.

// File: rtl/spi_reg_pkg.sv
`timescale 1ns/1ps
package spi_reg_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  // Next register pointer, wrapping at the last register of the file.
  function automatic logic [ADDR_W-1:0] ptr_next(input logic [ADDR_W-1:0] p, input int depth);
    if (int'(p) + 1 >= depth) return '0;
    return p + 1'b1;
  endfunction

endpackage

// File: rtl/spi_reg_sync.sv
`timescale 1ns/1ps
module spi_reg_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/spi_reg_rx.sv
`timescale 1ns/1ps
module spi_reg_rx
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sdi,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              first_byte
);

  logic [BIT_CNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0]    shreg;
  logic                 last_bit_w;

  assign last_bit_w = (bit_cnt == BIT_CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_done  <= 1'b0;
      first_byte <= 1'b1;
    end else if (!cs_act) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_done  <= 1'b0;
      first_byte <= 1'b1;
    end else begin
      byte_done <= 1'b0;
      if (sck_rise) begin
        shreg   <= {shreg[BYTE_W-2:0], sdi};
        bit_cnt <= bit_cnt + 1'b1;
        if (last_bit_w) byte_done <= 1'b1;
      end
      if (byte_done) first_byte <= 1'b0;
    end
  end

  assign byte_val = shreg;

  // R8: a deselect always restarts the bit position
  assert_bitcnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == '0));

  // R4: a completed byte is reported for one cycle only
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

endmodule

// File: rtl/spi_reg_tx.sv
`timescale 1ns/1ps
module spi_reg_tx
  import spi_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_fall,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  output logic              sdo
);

  logic [BYTE_W-1:0] txreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txreg <= '0;
      sdo   <= 1'b0;
    end else if (!cs_act) begin
      txreg <= '0;
      sdo   <= 1'b0;
    end else if (load) begin
      txreg <= load_val;
    end else if (sck_fall) begin
      sdo   <= txreg[BYTE_W-1];
      txreg <= {txreg[BYTE_W-2:0], 1'b0};
    end
  end

  // R2: output only moves after a falling edge while selected
  assert_sdo_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act) && !$past(sck_fall)) |-> $stable(sdo));

  // R5: a fetch never collides with a shift edge
  assert_load_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && sck_fall));

  // R9: deselect returns the output to 0
  assert_sdo_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo);

endmodule

// File: rtl/spi_reg_slave.sv
`timescale 1ns/1ps
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int NUM_REGS    = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_sdi,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);

  localparam int N_SYNC = 3;

  logic [N_SYNC-1:0] raw_w, synced_w;
  logic              cs_act, sck_s, sdi_s, sck_d;
  logic              sck_rise_w, sck_fall_w;
  logic              rx_done_w, rx_first_w;
  logic [BYTE_W-1:0] rx_byte_w;
  cmd_t              cmd_w;
  logic              step_q, rd_mode;
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] wdata_q;
  logic              fetch_w;

  assign raw_w = {spi_cs_n, spi_sck, spi_sdi};

  spi_reg_sync #(.STAGES(SYNC_STAGES), .W(N_SYNC), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_w), .q_o(synced_w)
  );

  assign cs_act = ~synced_w[2];
  assign sck_s  = synced_w[1];
  assign sdi_s  = synced_w[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign sck_rise_w = cs_act & sck_s & ~sck_d;
  assign sck_fall_w = cs_act & ~sck_s & sck_d;

  spi_reg_rx u_rx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise_w), .sdi(sdi_s),
    .byte_done(rx_done_w), .byte_val(rx_byte_w), .first_byte(rx_first_w)
  );

  assign cmd_w = cmd_t'(rx_byte_w);

  // Command decode and pointer stepping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_mode <= 1'b0;
      ptr     <= '0;
      step_q  <= 1'b0;
      wdata_q <= '0;
    end else if (!cs_act) begin
      rd_mode <= 1'b0;
      step_q  <= 1'b0;
    end else begin
      step_q <= 1'b0;
      if (rx_done_w) begin
        wdata_q <= rx_byte_w;
        if (rx_first_w) begin
          rd_mode <= cmd_w.rd;
          ptr     <= cmd_w.addr;
          step_q  <= cmd_w.rd;
        end else begin
          step_q  <= 1'b1;
        end
      end
      if (step_q) ptr <= ptr_next(ptr, NUM_REGS);
    end
  end

  assign fetch_w = step_q & rd_mode;

  spi_reg_tx u_tx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_fall(sck_fall_w),
    .load(fetch_w), .load_val(reg_rdata_i), .sdo(spi_sdo)
  );

  assign spi_sdo_oe  = cs_act;
  assign reg_addr_o  = ptr;
  assign reg_wdata_o = wdata_q;
  assign reg_we_o    = step_q & ~rd_mode;

  // R6: every access moves the pointer to its wrapped successor
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q && cs_act) |=> (ptr == ptr_next($past(ptr), NUM_REGS)));

  // R3: direction is fixed once the command byte has been taken
  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act) && !$past(rx_done_w && rx_first_w)) |-> $stable(rd_mode));

  // R4: the write strobe lasts a single cycle
  assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  // R7: no write and no drive without select
  assert_we_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> spi_sdo_oe);

endmodule

// File: tb/spi_reg_slave_tb_top.sv
`timescale 1ns/1ps
module spi_reg_slave_tb_top;

  localparam int NREG = 16;
  localparam int HALF = 104;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       sdi = 1'b0;
  logic       sdo, sdo_oe, we;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;

  logic [7:0] mem [NREG];
  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  int         we_cnt = 0;
  int         n_cmp = 0;
  int         n_bad = 0;
  int         cycles = 0;

  always #4 clk = ~clk;

  spi_reg_slave #(.NUM_REGS(NREG), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_rdata_i(rdata)
  );

  assign rdata = (int'(addr) < NREG) ? mem[addr[3:0]] : 8'h00;

  always @(posedge clk) begin
    if (we) begin
      mem[addr[3:0]] <= wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  function automatic logic [7:0] pat(input int s, input int k, input int m);
    return 8'((s * 13 + k * 7 + m * 91 + 90) % 256);
  endfunction

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      report();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One transaction of nbits bits; m3 selects clock-idle-high
  task automatic spi_txn(input bit m3, input int nbits);
    sck = m3;
    #50;
    cs_n = 1'b0;
    #HALF;
    chk("R7 oe while selected", int'(sdo_oe), 1);
    for (int b = 0; b < nbits; b++) begin
      int bi, bt;
      bi = b / 8;
      bt = 7 - (b % 8);
      if (m3) begin
        sck = 1'b0;
        sdi = txb[bi][bt];
        #HALF;
        rxb[bi][bt] = sdo;
        sck = 1'b1;
        #HALF;
      end else begin
        sdi = txb[bi][bt];
        #HALF;
        rxb[bi][bt] = sdo;
        sck = 1'b1;
        #HALF;
        sck = 1'b0;
      end
    end
    #HALF;
    cs_n = 1'b1;
    #300;
    chk("R7 oe after deselect", int'(sdo_oe), 0);
  endtask

  initial begin
    int w0;
    logic [7:0] keep;
    for (int i = 0; i < NREG; i++) mem[i] = 8'(i * 37 + 5);
    for (int i = 0; i < 8; i++) rxb[i] = '0;
    #40;
    rst_n = 1'b1;
    #20;
    chk("R7 reset oe", int'(sdo_oe), 0);
    chk("R4 reset we", int'(we), 0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < NREG; s++) begin
        txb[0] = {1'b0, 7'(s)};
        for (int k = 0; k < 3; k++) txb[k+1] = pat(s, k, m);
        w0 = we_cnt;
        spi_txn(m == 1, 32);
        chk("R9 sdo during command", int'(rxb[0]), 0);
        chk("R4 strobe count", we_cnt - w0, 3);
        for (int k = 0; k < 3; k++)
          chk("R4 R6 stored byte", int'(mem[(s + k) % NREG]), int'(pat(s, k, m)));

        txb[0] = {1'b1, 7'(s)};
        for (int k = 1; k < 4; k++) txb[k] = 8'h00;
        w0 = we_cnt;
        spi_txn(m == 1, 32);
        chk("R3 no write in read", we_cnt - w0, 0);
        for (int k = 0; k < 3; k++)
          chk(m == 1 ? "R5 R1 R2 read mode3" : "R5 R1 R2 read mode0",
              int'(rxb[k+1]), int'(pat(s, k, m)));
      end
    end

    // R8: cut a write short in the middle of its first data byte
    for (int m = 0; m < 2; m++) begin
      keep = mem[3];
      txb[0] = 8'h03;
      txb[1] = 8'hC3;
      w0 = we_cnt;
      spi_txn(m == 1, 12);
      chk("R8 no write from partial byte", we_cnt - w0, 0);
      chk("R8 register unchanged", int'(mem[3]), int'(keep));
      txb[0] = 8'h83;
      txb[1] = 8'h00;
      spi_txn(m == 1, 16);
      chk("R8 realigned read", int'(rxb[1]), int'(keep));
    end

    report();
  end

endmodule